// File: doc/BRIEF.md
# Oscillator Enable and Ready Gating Controller

This block is the digital control shell around one on-chip RC oscillator. Software switches the oscillator on and off with one enable bit. While the oscillator is enabled and reports that it is alive, the block brings the raw oscillator square wave into the system clock domain through a synchronizer and counts its rising edges. After a set number of consecutive edges, a hardware-owned ready flag rises. From that point on, the oscillator waveform is passed to the downstream clock tree. Until ready is set, that output is held low.

The block also drives two tuning fields to the analog oscillator. The first is an 8-bit calibration value, captured from a fuse input port whenever reset is active. Software cannot write it. The second is a 5-bit trim value that software can write, and it resets to the middle of its range. A sticky ready-event flag, with its own enable bit and a write-one-to-clear strobe, provides an interrupt when the oscillator becomes usable.

Top module: `osc_ready_ctrl`

## Requirements
- R1: While `rst` is high, `cal_out` is loaded from `fuse_cal`. After reset it holds that value, whatever `fuse_cal` does later, and the block has no write path to it.
- R2: `trim_out` resets to 5'b10000. A cycle with `trim_we` high loads `trim_val`, which appears on `trim_out` after the next clock edge.
- R3: A cycle with `ctl_we` high loads `ctl_on` into the enable bit. The enable bit is visible on `osc_en` after the next edge, and it resets to 0.
- R4: `ready` rises on the clock edge where the synchronized oscillator shows its SETTLE_CYC-th rising edge. Only edges seen while the enable bit is 1 and `osc_alive` is 1 are counted. Any cycle with the enable bit at 0 or `osc_alive` at 0 restarts the count from zero. Only hardware sets `ready`, and once set it stays set while enabled.
- R5: `clk_gated` is 0 whenever `ready` is 0. While `ready` is 1, `clk_gated` is a registered copy of the synchronized oscillator level (SYNC_STAGES flops), so it starts at the beginning of a high phase.
- R6: `rdy_flag` becomes 1 on the edge where `ready` rises and stays 1 until a cycle with `rdy_clr` high clears it. If the set and the clear fall in the same cycle, the set wins.
- R7: Writing 0 to the enable bit clears `ready` and `clk_gated` on the same edge that clears `osc_en`.
- R8: `irq` equals `rdy_flag` AND the interrupt enable bit. That bit is written from `ie_val` on a cycle with `ie_we` high and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fuse_cal | input | 8 | Factory calibration value from fuses |
| ctl_we | input | 1 | Write strobe for the enable bit |
| ctl_on | input | 1 | New enable bit value |
| trim_we | input | 1 | Write strobe for the trim field |
| trim_val | input | 5 | New trim value |
| ie_we | input | 1 | Write strobe for the interrupt enable |
| ie_val | input | 1 | New interrupt enable value |
| rdy_clr | input | 1 | Write-one-to-clear strobe for the ready flag |
| osc_clk_in | input | 1 | Raw oscillator waveform |
| osc_alive | input | 1 | Analog indication that the oscillator is running |
| osc_en | output | 1 | Enable to the analog oscillator |
| cal_out | output | 8 | Calibration field to the oscillator |
| trim_out | output | 5 | Trim field to the oscillator |
| ready | output | 1 | Hardware ready flag |
| clk_gated | output | 1 | Oscillator waveform released downstream |
| rdy_flag | output | 1 | Sticky ready-event flag |
| irq | output | 1 | Ready interrupt |

## Verification
The embedded assertions check four things on every cycle. Ready never stands without the enable bit. The gated output never toggles high without ready. A disable write always drops ready on the next edge. The calibration field never moves outside reset. Other behaviour appears only in scripted scenarios: the exact edge count to ready, the count restarting when `osc_alive` drops mid-settle, the trim midpoint and rewrites, fuse changes being ignored after reset, and the sticky flag clearing with the interrupt masked and unmasked. These are compared cycle by cycle against a behavioural model.

// File: rtl/osc_ready_pkg.sv
package osc_ready_pkg;
    localparam int CAL_W  = 8;
    localparam int TRIM_W = 5;

    typedef logic [CAL_W-1:0]  cal_t;
    typedef logic [TRIM_W-1:0] trim_t;

    typedef struct packed {
        logic on;
        logic ie;
    } ctl_t;

    function automatic trim_t trim_mid();
        trim_t v;
        v = '0;
        v[TRIM_W-1] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic lvl,
    output logic rise
);
    logic [STAGES:0] chain;

    generate
        for (genvar i = 0; i <= STAGES; i++) begin : g_ff
            always_ff @(posedge clk) begin
                if (rst)         chain[i] <= 1'b0;
                else if (i == 0) chain[i] <= raw;
                else             chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/osc_settle.sv
module osc_settle #(
    parameter int SETTLE_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic on_q,
    input  logic on_d,
    input  logic alive,
    input  logic rise,
    output logic rdy_d,
    output logic rdy_q
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt;
    logic          hit;

    assign hit = on_q & alive & rise & (cnt == LAST);

    always_comb begin
        if (!on_d)      rdy_d = 1'b0;
        else if (rdy_q) rdy_d = 1'b1;
        else            rdy_d = hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            rdy_q <= 1'b0;
        end else begin
            rdy_q <= rdy_d;
            if (!on_q || !alive)    cnt <= '0;
            else if (rise && !rdy_q) cnt <= cnt + 1'b1;
        end
    end

    AST_RDY_NEEDS_ON: assert property (@(posedge clk) disable iff (rst)
        rdy_q |-> on_q); // R4

    AST_RDY_RISE_COUNTED: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_q) |-> $past(on_q) && $past(alive) && $past(rise)); // R4
endmodule

// File: rtl/osc_ready_ctrl.sv
module osc_ready_ctrl
    import osc_ready_pkg::*;
#(
    parameter int SETTLE_CYC  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CAL_W-1:0]  fuse_cal,
    input  logic              ctl_we,
    input  logic              ctl_on,
    input  logic              trim_we,
    input  logic [TRIM_W-1:0] trim_val,
    input  logic              ie_we,
    input  logic              ie_val,
    input  logic              rdy_clr,
    input  logic              osc_clk_in,
    input  logic              osc_alive,
    output logic              osc_en,
    output logic [CAL_W-1:0]  cal_out,
    output logic [TRIM_W-1:0] trim_out,
    output logic              ready,
    output logic              clk_gated,
    output logic              rdy_flag,
    output logic              irq
);
    ctl_t  ctl_q, ctl_d;
    cal_t  cal_q;
    trim_t trim_q;
    logic  osc_lvl, osc_rise;
    logic  rdy_d, rdy_q;
    logic  gate_q, flag_q;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_we) ctl_d.on = ctl_on;
        if (ie_we)  ctl_d.ie = ie_val;
    end

    osc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (osc_clk_in),
        .lvl  (osc_lvl),
        .rise (osc_rise)
    );

    osc_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst   (rst),
        .on_q  (ctl_q.on),
        .on_d  (ctl_d.on),
        .alive (osc_alive),
        .rise  (osc_rise),
        .rdy_d (rdy_d),
        .rdy_q (rdy_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            cal_q  <= fuse_cal;
            trim_q <= trim_mid();
            gate_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            ctl_q  <= ctl_d;
            if (trim_we) trim_q <= trim_val;
            gate_q <= osc_lvl & rdy_d;
            if (rdy_d && !rdy_q) flag_q <= 1'b1;
            else if (rdy_clr)    flag_q <= 1'b0;
        end
    end

    assign osc_en    = ctl_q.on;
    assign cal_out   = cal_q;
    assign trim_out  = trim_q;
    assign ready     = rdy_q;
    assign clk_gated = gate_q;
    assign rdy_flag  = flag_q;
    assign irq       = flag_q & ctl_q.ie;

    AST_CAL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(cal_out)); // R1

    AST_GATE_NEEDS_RDY: assert property (@(posedge clk) disable iff (rst)
        clk_gated |-> ready); // R5

    AST_OFF_DROPS_RDY: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && !ctl_on) |=> !ready && !clk_gated && !osc_en); // R7

    AST_FLAG_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> rdy_flag); // R6
endmodule

// File: tb/sim_osc_ready_ctrl.sv
module sim_osc_ready_ctrl;
    localparam int SETTLE = 5;
    localparam int SYNC   = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] fuse_cal = 8'hA5;
    logic       ctl_we = 0, ctl_on = 0, trim_we = 0, ie_we = 0, ie_val = 0, rdy_clr = 0;
    logic [4:0] trim_val = '0;
    logic       osc_clk_in = 0, osc_alive = 0, osc_run = 0;
    logic       osc_en, ready, clk_gated, rdy_flag, irq;
    logic [7:0] cal_out;
    logic [4:0] trim_out;

    int total = 0, bad = 0, cyc = 0;

    always #4 clk = ~clk;

    osc_ready_ctrl #(.SETTLE_CYC(SETTLE), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst(rst), .fuse_cal(fuse_cal), .ctl_we(ctl_we), .ctl_on(ctl_on),
        .trim_we(trim_we), .trim_val(trim_val), .ie_we(ie_we), .ie_val(ie_val),
        .rdy_clr(rdy_clr), .osc_clk_in(osc_clk_in), .osc_alive(osc_alive),
        .osc_en(osc_en), .cal_out(cal_out), .trim_out(trim_out), .ready(ready),
        .clk_gated(clk_gated), .rdy_flag(rdy_flag), .irq(irq)
    );

    // behavioural reference
    bit hist[$];
    int m_cnt;
    bit m_on, m_ie, m_rdy, m_g, m_flag;
    int m_trim, m_cal;

    always @(posedge clk) begin
        bit rise_seen, n_on, n_rdy;
        if (rst) begin
            hist = {};
            for (int i = 0; i <= SYNC; i++) hist.push_back(1'b0);
            m_cnt = 0; m_on = 0; m_ie = 0; m_rdy = 0; m_g = 0; m_flag = 0;
            m_trim = 16; m_cal = fuse_cal;
        end else begin
            rise_seen = hist[SYNC-1] && !hist[SYNC];
            n_on = ctl_we ? ctl_on : m_on;
            if (!n_on) n_rdy = 0;
            else if (m_rdy) n_rdy = 1;
            else n_rdy = m_on && osc_alive && rise_seen && (m_cnt == SETTLE-1);
            m_g = hist[SYNC-1] && n_rdy;
            if (n_rdy && !m_rdy) m_flag = 1;
            else if (rdy_clr) m_flag = 0;
            if (!m_on || !osc_alive) m_cnt = 0;
            else if (rise_seen && !m_rdy) m_cnt++;
            m_rdy = n_rdy;
            m_on = n_on;
            if (ie_we) m_ie = ie_val;
            if (trim_we) m_trim = trim_val;
            hist.push_front(osc_clk_in);
            void'(hist.pop_back());
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s cycle=%0d actual=%0d expected=%0d", req, what, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk("R1", "cal_out", cal_out, m_cal);
            chk("R2", "trim_out", trim_out, m_trim);
            chk("R3", "osc_en", osc_en, m_on);
            chk("R4", "ready", ready, m_rdy);
            chk("R5", "clk_gated", clk_gated, m_g);
            chk("R6", "rdy_flag", rdy_flag, m_flag);
            chk("R8", "irq", irq, m_flag & m_ie);
        end
    end

    // oscillator: period of 6 system cycles when running
    int ph = 0;
    always @(negedge clk) begin
        if (osc_run) begin
            ph = (ph + 1) % 6;
            osc_clk_in <= (ph < 3);
        end else begin
            osc_clk_in <= 1'b0;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ctl(input bit v);
        @(negedge clk); ctl_we = 1; ctl_on = v;
        @(negedge clk); ctl_we = 0;
    endtask

    int waited;

    initial begin
        idle(3);
        @(negedge clk); rst = 0;
        // reset state
        chk("R2", "trim reset midpoint", trim_out, 16);
        chk("R1", "cal reset load", cal_out, 8'hA5);
        chk("R4", "ready low after reset", ready, 0);
        chk("R5", "gate low after reset", clk_gated, 0);
        // fuse change after reset must not reach cal_out (R1)
        fuse_cal = 8'h3C;
        idle(2);
        chk("R1", "cal ignores fuse", cal_out, 8'hA5);
        // trim write (R2)
        @(negedge clk); trim_we = 1; trim_val = 5'd7;
        @(negedge clk); trim_we = 0;
        chk("R2", "trim written", trim_out, 7);
        // interrupt enable, oscillator on
        @(negedge clk); ie_we = 1; ie_val = 1;
        @(negedge clk); ie_we = 0;
        osc_run = 1; osc_alive = 1;
        pulse_ctl(1);
        chk("R3", "osc_en set", osc_en, 1);
        chk("R5", "gate low while settling", clk_gated, 0);
        waited = 0;
        while (!ready && waited < 200) begin idle(1); waited++; end
        chk("R4", "ready reached", ready, 1);
        chk("R8", "irq on ready", irq, 1);
        idle(20);
        // W1C clear (R6)
        @(negedge clk); rdy_clr = 1;
        @(negedge clk); rdy_clr = 0;
        chk("R6", "flag cleared", rdy_flag, 0);
        chk("R4", "ready stays", ready, 1);
        // disable (R7)
        pulse_ctl(0);
        chk("R7", "ready dropped", ready, 0);
        chk("R7", "gate dropped", clk_gated, 0);
        idle(12);
        // alive drop mid-settle restarts count (R4)
        @(negedge clk); ie_we = 1; ie_val = 0;
        @(negedge clk); ie_we = 0;
        pulse_ctl(1);
        idle(15);
        osc_alive = 0;
        idle(4);
        chk("R4", "no ready while dead", ready, 0);
        osc_alive = 1;
        idle(60);
        chk("R4", "ready after restart", ready, 1);
        chk("R8", "irq masked", irq, 0);
        chk("R6", "flag sticky", rdy_flag, 1);
        idle(10);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule